// File: doc/BRIEF.md
# Sparse-Trellis Log-Domain Viterbi Forward Engine

This block runs the forward (add-compare-select) recursion of a Viterbi decoder for a 24-state model whose states are arranged as four columns of six. Metrics are negated log probabilities, so products become additions and the best path is the one with the smallest metric. Each state can be reached from only two predecessors. Each compare node therefore weighs two candidate sums, keeps the smaller one, adds the observation cost of the state, and records which of the two candidates won. The survivor bits are handed to a traceback stage outside this block.

A caller first loads a prior-cost vector, then feeds one vector of observation costs per timestep through a valid/ready handshake. When the timestep is finished, the engine publishes the new metric vector and the survivor bits, and marks the moment with a one-cycle done pulse. The transition-cost pairs are constant parameters. The parameter `NODES` sets how many compare nodes work in parallel (1, 4, 8, 12 or 24). This trades cycles per timestep against logic. With 24 nodes every node is wired to fixed predecessors.

Top module: `vit_engine`

## Requirements
- R1: After reset, obs_ready_o is 1, done_o is 0, and metric_o and surv_o are all zero.
- R2: A high init_i while obs_ready_o is 1 copies prior_i into metric_o at the next clock edge, and those values become the metrics of the previous timestep. If init_i and a handshake occur in the same cycle, the new priors are used. init_i is ignored while the engine is busy.
- R3: A handshake is a cycle in which obs_valid_i and obs_ready_o are both 1. It latches obs_i, and obs_ready_o drops at the following cycle. Changes on obs_i after the handshake do not affect the result.
- R4: done_o is high for exactly one cycle, after the (24/NODES)-th clock edge that follows the handshake edge. In that cycle obs_ready_o is 1 again, and metric_o and surv_o hold the new results.
- R5: With states numbered 0 to 23, state k has the candidate pair (k-1, k). States 0, 6, 12 and 18 instead use ((k-1) mod 24, k+5). The first member of a pair is candidate 0.
- R6: The new metric of state k is min(m[p0]+lo[k], m[p1]+hi[k]) + obs[k], where lo and hi are the per-state transition costs. All vectors are packed with state k at bits [16k+15:16k].
- R7: Survivor bit k of surv_o is 1 only when candidate 1 is strictly smaller than candidate 0. A tie gives 0. surv_o changes only when done_o is high.
- R8: Every 16-bit addition saturates at 0xFFFF instead of wrapping.
- R9: Results and survivor bits are identical for every supported NODES value. Only the latency differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Load prior costs as the starting metrics |
| prior_i | input | NUM_STATES*METRIC_W | Prior cost per state |
| obs_valid_i | input | 1 | Observation vector valid |
| obs_ready_o | output | 1 | Engine idle and able to accept |
| obs_i | input | NUM_STATES*METRIC_W | Observation cost per state |
| done_o | output | 1 | One-cycle pulse at the end of a timestep |
| metric_o | output | NUM_STATES*METRIC_W | Current path metrics |
| surv_o | output | NUM_STATES | Survivor select bit per state |

## Verification
The checker checks the protocol rules on every cycle: the done pulse comes exactly 24/NODES edges after acceptance and lasts one cycle, ready drops after a handshake, metrics change only at done or after a prior load, and survivor bits change only at done. The arithmetic can only be shown by the bench's scenarios, which run three configurations (1, 4 and 24 nodes) side by side against an arithmetic model. These scenarios cover the special predecessor pairs, the tie rule, saturation, and prior loads that arrive during a run or in the same cycle as a handshake.

// File: rtl/vit_pkg.sv
package vit_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} vit_state_e;

  // candidate 0: previous state in the column chain, wrapping at the start
  function automatic int pred_lo(int k, int num_states);
    return (k == 0) ? num_states - 1 : k - 1;
  endfunction

  // candidate 1: the column head reaches back to the tail of its own column
  function automatic int pred_hi(int k, int group);
    return (k % group == 0) ? k + group - 1 : k;
  endfunction
endpackage

// File: rtl/vit_satadd.sv
module vit_satadd #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  logic [W:0] sum;
  assign sum = {1'b0, a_i} + {1'b0, b_i};
  assign s_o = sum[W] ? '1 : sum[W-1:0];
endmodule

// File: rtl/vit_node.sv
module vit_node #(
  parameter int W = 16
) (
  input  logic [W-1:0] c_lo_i,
  input  logic [W-1:0] c_hi_i,
  input  logic [W-1:0] obs_i,
  output logic [W-1:0] metric_o,
  output logic         sel_o
);
  logic [W-1:0] best;
  assign sel_o = c_hi_i < c_lo_i;  // tie keeps candidate 0
  assign best  = sel_o ? c_hi_i : c_lo_i;
  vit_satadd #(.W(W)) u_obs_add (.a_i(best), .b_i(obs_i), .s_o(metric_o));
endmodule

// File: rtl/vit_ctrl.sv
module vit_ctrl
  import vit_pkg::*;
#(
  parameter int STEPS  = 1,
  parameter int STEP_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              obs_valid_i,
  output logic              ready_o,
  output logic              accept_o,
  output logic              last_o,
  output logic [STEP_W-1:0] step_o,
  output logic              done_o
);
  vit_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q;

  assign ready_o  = state_q == ST_IDLE;
  assign accept_o = ready_o && obs_valid_i;
  assign last_o   = (state_q == ST_RUN) && (step_q == STEP_W'(STEPS - 1));
  assign step_o   = step_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (obs_valid_i) begin
          state_q <= ST_RUN;
          step_q  <= '0;
        end
        default: if (last_o) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/vit_engine.sv
module vit_engine
  import vit_pkg::*;
#(
  parameter int NUM_STATES = 24,
  parameter int GROUP      = 6,
  parameter int METRIC_W   = 16,
  parameter int NODES      = 24,
  parameter logic [NUM_STATES*METRIC_W-1:0] TRANS_LO = '0,
  parameter logic [NUM_STATES*METRIC_W-1:0] TRANS_HI = '0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           init_i,
  input  logic [NUM_STATES*METRIC_W-1:0] prior_i,
  input  logic                           obs_valid_i,
  output logic                           obs_ready_o,
  input  logic [NUM_STATES*METRIC_W-1:0] obs_i,
  output logic                           done_o,
  output logic [NUM_STATES*METRIC_W-1:0] metric_o,
  output logic [NUM_STATES-1:0]          surv_o
);
  localparam int STEPS  = NUM_STATES / NODES;
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int IDX_W  = $clog2(NUM_STATES);

  typedef logic [METRIC_W-1:0] metric_t;

  metric_t [NUM_STATES-1:0] prev_q, obs_q, prior_v, obs_v, shifted_m;
  logic    [NUM_STATES-1:0] surv_q, shifted_s;
  metric_t [NODES-1:0]      chunk_m;
  logic    [NODES-1:0]      chunk_s;
  logic                     ready, accept, last;
  logic    [STEP_W-1:0]     step;

  assign prior_v     = prior_i;
  assign obs_v       = obs_i;
  assign metric_o    = prev_q;
  assign surv_o      = surv_q;
  assign obs_ready_o = ready;

  vit_ctrl #(.STEPS(STEPS), .STEP_W(STEP_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .obs_valid_i(obs_valid_i),
    .ready_o    (ready),
    .accept_o   (accept),
    .last_o     (last),
    .step_o     (step),
    .done_o     (done_o)
  );

  for (genvar n = 0; n < NODES; n++) begin : g_node
    logic [IDX_W-1:0] k_idx, lo_idx, hi_idx;
    metric_t          c_lo, c_hi;

    // with one step per timestep, step is constant zero and the routing folds to wires
    assign k_idx  = IDX_W'(int'(step) * NODES + n);
    assign lo_idx = IDX_W'(pred_lo(int'(k_idx), NUM_STATES));
    assign hi_idx = IDX_W'(pred_hi(int'(k_idx), GROUP));

    if (STEPS == 1 && TRANS_LO[n*METRIC_W +: METRIC_W] == '0) begin : g_lo_wire
      assign c_lo = prev_q[lo_idx];
    end else begin : g_lo_add
      vit_satadd #(.W(METRIC_W)) u_add (
        .a_i(prev_q[lo_idx]), .b_i(TRANS_LO[k_idx*METRIC_W +: METRIC_W]), .s_o(c_lo));
    end

    if (STEPS == 1 && TRANS_HI[n*METRIC_W +: METRIC_W] == '0) begin : g_hi_wire
      assign c_hi = prev_q[hi_idx];
    end else begin : g_hi_add
      vit_satadd #(.W(METRIC_W)) u_add (
        .a_i(prev_q[hi_idx]), .b_i(TRANS_HI[k_idx*METRIC_W +: METRIC_W]), .s_o(c_hi));
    end

    vit_node #(.W(METRIC_W)) u_node (
      .c_lo_i  (c_lo),
      .c_hi_i  (c_hi),
      .obs_i   (obs_q[k_idx]),
      .metric_o(chunk_m[n]),
      .sel_o   (chunk_s[n])
    );
  end

  if (STEPS == 1) begin : g_direct
    assign shifted_m = chunk_m;
    assign shifted_s = chunk_s;
  end else begin : g_shift
    metric_t [NUM_STATES-1:0] nxt_m_q;
    logic    [NUM_STATES-1:0] nxt_s_q;
    assign shifted_m = {chunk_m, nxt_m_q[NUM_STATES-1:NODES]};
    assign shifted_s = {chunk_s, nxt_s_q[NUM_STATES-1:NODES]};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        nxt_m_q <= '0;
        nxt_s_q <= '0;
      end else if (!ready) begin
        nxt_m_q <= shifted_m;
        nxt_s_q <= shifted_s;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      obs_q  <= '0;
      surv_q <= '0;
    end else begin
      if (accept) obs_q <= obs_v;
      if (init_i && ready) prev_q <= prior_v;
      else if (last)       prev_q <= shifted_m;
      if (last) surv_q <= shifted_s;
    end
  end
endmodule

// File: rtl/vit_chk.sv
module vit_chk #(
  parameter int STEPS = 1,
  parameter int VW    = 384,
  parameter int NS    = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          init_i,
  input logic          obs_valid_i,
  input logic          obs_ready_o,
  input logic          done_o,
  input logic [VW-1:0] metric_o,
  input logic [NS-1:0] surv_o
);
  int lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= 0;
    else if (obs_valid_i && obs_ready_o) lat_q <= 0;
    else if (!obs_ready_o) lat_q <= lat_q + 1;
  end

  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_q == STEPS); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_DONE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> obs_ready_o); // R4
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    obs_valid_i && obs_ready_o |=> !obs_ready_o); // R3
  AST_SURV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(surv_o)); // R7
  AST_METRIC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o && !$past(init_i && obs_ready_o) |-> $stable(metric_o)); // R2
endmodule

bind vit_engine vit_chk #(
  .STEPS(NUM_STATES / NODES), .VW(NUM_STATES * METRIC_W), .NS(NUM_STATES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .init_i     (init_i),
  .obs_valid_i(obs_valid_i),
  .obs_ready_o(obs_ready_o),
  .done_o     (done_o),
  .metric_o   (metric_o),
  .surv_o     (surv_o)
);

// File: tb/tb_vit_engine.sv
module tb_vit_engine;
  localparam int NS = 24;
  localparam int MW = 16;
  localparam int VW = NS * MW;

  function automatic logic [VW-1:0] mk_lo();
    logic [VW-1:0] v;
    for (int k = 0; k < NS; k++) v[k*MW +: MW] = (k % 4 == 0) ? 16'd0 : MW'((k * 37) % 200 + 1);
    return v;
  endfunction
  function automatic logic [VW-1:0] mk_hi();
    logic [VW-1:0] v;
    for (int k = 0; k < NS; k++) v[k*MW +: MW] = (k % 5 == 0) ? 16'd0 : MW'((k * 53) % 300 + 3);
    return v;
  endfunction
  localparam logic [VW-1:0] LO_V = mk_lo();
  localparam logic [VW-1:0] HI_V = mk_hi();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0;
  logic obs_valid = 1'b0;
  logic [VW-1:0] prior = '0;
  logic [VW-1:0] obs = '0;
  logic [VW-1:0] met [3];
  logic [NS-1:0] sv [3];
  logic dn [3];
  logic rd [3];
  int steps_of [3] = '{24, 6, 1};

  always #4 clk = ~clk;

  vit_engine #(.NODES(1), .TRANS_LO(LO_V), .TRANS_HI(HI_V)) dut (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .prior_i(prior), .obs_valid_i(obs_valid),
    .obs_ready_o(rd[0]), .obs_i(obs), .done_o(dn[0]), .metric_o(met[0]), .surv_o(sv[0]));
  vit_engine #(.NODES(4), .TRANS_LO(LO_V), .TRANS_HI(HI_V)) dut_p4 (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .prior_i(prior), .obs_valid_i(obs_valid),
    .obs_ready_o(rd[1]), .obs_i(obs), .done_o(dn[1]), .metric_o(met[1]), .surv_o(sv[1]));
  vit_engine #(.NODES(24), .TRANS_LO(LO_V), .TRANS_HI(HI_V)) dut_p24 (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .prior_i(prior), .obs_valid_i(obs_valid),
    .obs_ready_o(rd[2]), .obs_i(obs), .done_o(dn[2]), .metric_o(met[2]), .surv_o(sv[2]));

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int pm [NS];
  logic [NS-1:0] ps;
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(string req, string what, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int sat(int a, int b);
    return (a + b > 65535) ? 65535 : a + b;
  endfunction

  function automatic logic [VW-1:0] pm_vec();
    logic [VW-1:0] v;
    for (int k = 0; k < NS; k++) v[k*MW +: MW] = MW'(pm[k]);
    return v;
  endfunction

  task automatic model(logic [VW-1:0] ob);
    int nm [NS];
    for (int k = 0; k < NS; k++) begin
      int p0, p1, c0, c1;
      p0 = (k == 0) ? NS - 1 : k - 1;
      p1 = (k % 6 == 0) ? k + 5 : k;
      c0 = sat(pm[p0], int'(LO_V[k*MW +: MW]));
      c1 = sat(pm[p1], int'(HI_V[k*MW +: MW]));
      ps[k] = c1 < c0;
      nm[k] = sat(ps[k] ? c1 : c0, int'(ob[k*MW +: MW]));
    end
    for (int k = 0; k < NS; k++) pm[k] = nm[k];
  endtask

  task automatic run_step(bit init_same, bit init_mid, logic [VW-1:0] pri, logic [VW-1:0] ob);
    @(negedge clk);
    obs = ob;
    obs_valid = 1'b1;
    if (init_same) begin init = 1'b1; prior = pri; end
    @(negedge clk);
    obs_valid = 1'b0;
    init = 1'b0;
    obs = ~ob;  // R3: must not reach the result
    for (int d = 0; d < 3; d++) chk("R3", "ready after accept", VW'(rd[d]), VW'(0));
    if (init_mid) begin init = 1'b1; prior = pri; end  // R2: ignored while busy
    if (init_same) for (int k = 0; k < NS; k++) pm[k] = int'(pri[k*MW +: MW]);
    model(ob);
    for (int c = 1; c <= 24; c++) begin
      @(negedge clk);
      init = 1'b0;
      for (int d = 0; d < 3; d++) begin
        chk("R4", "done timing", VW'(dn[d]), VW'(c == steps_of[d]));
        if (c == steps_of[d]) chk("R4", "ready at done", VW'(rd[d]), VW'(1));
      end
    end
    for (int d = 0; d < 3; d++) begin
      chk("R6 R8 R9", "metrics", met[d], pm_vec());
      chk("R5 R7 R9", "survivors", VW'(sv[d]), VW'(ps));
    end
  endtask

  function automatic logic [VW-1:0] rnd_vec(int mask);
    logic [VW-1:0] v;
    for (int k = 0; k < NS; k++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      v[k*MW +: MW] = MW'(int'(rng[15:0]) & mask);
    end
    return v;
  endfunction

  function automatic logic [VW-1:0] fill(int val);
    logic [VW-1:0] v;
    for (int k = 0; k < NS; k++) v[k*MW +: MW] = MW'(val);
    return v;
  endfunction

  initial begin
    logic [VW-1:0] pv;
    for (int k = 0; k < NS; k++) pm[k] = 0;
    repeat (3) @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      chk("R1", "reset ready", VW'(rd[d]), VW'(1));
      chk("R1", "reset done", VW'(dn[d]), VW'(0));
      chk("R1", "reset metrics", met[d], '0);
      chk("R1", "reset survivors", VW'(sv[d]), '0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R2: plain prior load
    pv = rnd_vec(16'h03FF);
    init = 1'b1; prior = pv;
    @(negedge clk);
    init = 1'b0;
    for (int k = 0; k < NS; k++) pm[k] = int'(pv[k*MW +: MW]);
    for (int d = 0; d < 3; d++) chk("R2", "prior load", met[d], pv);
    // R5 R6 R7 R9: varied observation vectors
    for (int t = 0; t < 6; t++) run_step(1'b0, 1'b0, '0, rnd_vec(16'h0FFF));
    // R5: column heads, state 5 cheap, others expensive
    pv = fill(1000);
    pv[5*MW +: MW] = 16'd0;
    run_step(1'b1, 1'b0, pv, fill(7));
    for (int d = 0; d < 3; d++) begin
      chk("R5", "state 0 picks candidate 1", VW'(sv[d][0]), VW'(1));
      chk("R5", "state 0 metric", VW'(met[d][0 +: MW]), VW'(7));
      chk("R5", "state 6 picks candidate 0", VW'(sv[d][6]), VW'(0));
      chk("R5", "state 6 metric", VW'(met[d][6*MW +: MW]), VW'(30));
    end
    // R2: init during a run is ignored; R2 also same-cycle load
    run_step(1'b0, 1'b1, fill(16'h0005), rnd_vec(16'h00FF));
    run_step(1'b1, 1'b0, rnd_vec(16'h1FFF), rnd_vec(16'h00FF));
    // R7 R8: all saturated, every pair ties
    run_step(1'b1, 1'b0, fill(16'hFFFF), fill(16'h0010));
    for (int d = 0; d < 3; d++) begin
      chk("R7", "tie gives zero", VW'(sv[d]), '0);
      chk("R8", "saturated metrics", met[d], fill(16'hFFFF));
    end
    // R8: saturation in the observation add
    run_step(1'b1, 1'b0, fill(16'hFF00), fill(16'h0FFF));
    for (int t = 0; t < 3; t++) run_step(1'b0, 1'b0, '0, rnd_vec(16'hFFFF));
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule